// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block keeps track of which power state a microcontroller is in and drives the gating signals that follow from it. The CPU asks for a wait or a stop. Interrupt lines, wake inputs and the reset end those states. The block then drives enables for the CPU clock, the peripheral clocks, the oscillator, the regulator full-performance request, and the three periodic timers: the real-time tick, the watchdog and the autonomous wakeup timer.

A stop request is not acted on while a non-volatile-memory command is in flight. It is kept pending and is taken once the memory goes idle. A select bit, read when the stop is accepted, picks one of two stop modes:

- **Pseudo-stop** keeps the oscillator running and leaves the timers alive. The return from it is immediate.
- **Full stop** turns the oscillator off. Waking from it passes through a programmable oscillator-restart delay before run resumes.

When debug is enabled, stop keeps the regulator at full performance and the clock unit running. An extra control bit also keeps the CPU and peripheral clocks running, so a debugger can reach peripherals.

Top module: `lpm_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the state code is 0 (run) and all seven enables are 1.
- R2: In run, a wait request moves the state to 1 (wait) at the next edge. In wait the CPU clock enable is 0, and the peripheral clock, oscillator, regulator and timer enables are 1.
- R3: Wait returns to run at the next edge on the non-maskable interrupt or the external IRQ. It also returns on any interrupt line whose pending bit and local enable bit are both 1 while the global mask input is 0. A masked line leaves the state in wait.
- R4: A stop request seen while the memory-busy flag is 1 leaves the state in run and is held pending. The stop is entered at the first edge where the flag is 0 and no wait request is present. A wait request takes priority over a stop request.
- R5: When a stop is accepted, the select bit picks pseudo-stop (state 2) when it is 1 and full stop (state 3) when it is 0. The bit is ignored at all other times. In pseudo-stop, the oscillator, real-time tick, watchdog and wakeup-timer enables are 1, and the CPU and peripheral clock enables are 0 unless R10 applies.
- R6: In full stop with debug disabled, the oscillator, CPU clock, peripheral clock, regulator, real-time tick and watchdog enables are 0. Only the wakeup-timer enable is 1.
- R7: Pseudo-stop and full stop end on any stop-wake input or on any R3 wake source. Wait and stop requests are ignored while in wait, pseudo-stop or full stop.
- R8: A wake from full stop with debug disabled enters state 4 (oscillator restart), loading the delay input D. The state then stays 4 for D+1 cycles before returning to run. In state 4 the enables for the oscillator, regulator and wakeup timer are 1 and all others are 0. Pseudo-stop wakes straight to run.
- R9: With debug enabled, pseudo-stop and full stop hold the regulator and oscillator enables at 1, and full stop also keeps the real-time tick and watchdog enables at 1. A wake from full stop with debug enabled goes straight to run.
- R10: With debug enabled and the clock-keep bit set, the CPU and peripheral clock enables are 1 in pseudo-stop and full stop.
- R11: The state output encodes run=0, wait=1, pseudo-stop=2, full stop=3, oscillator restart=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_req | input | 1 | CPU wait request |
| stop_req | input | 1 | CPU stop request |
| nvm_busy | input | 1 | Non-volatile-memory command active |
| pstop_sel | input | 1 | 1 selects pseudo-stop, 0 full stop, read on acceptance |
| xirq | input | 1 | Non-maskable interrupt |
| irq_ext | input | 1 | External interrupt pin |
| irq_pend | input | NUM_IRQ | Pending maskable interrupt lines |
| irq_en | input | NUM_IRQ | Local enables for those lines |
| gmask | input | 1 | Global interrupt mask, 1 masks |
| stop_wake | input | NUM_SWAKE | Keypad, serial and bus-transceiver wake inputs |
| dbg_en | input | 1 | Debug enabled |
| dbg_keep | input | 1 | Keep clocks alive in stop while debugging |
| osc_delay | input | DW | Oscillator restart delay in cycles |
| lp_state | output | 3 | Current state code |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| vreg_full | output | 1 | Regulator full-performance request |
| rti_en | output | 1 | Real-time tick enable |
| cop_en | output | 1 | Watchdog enable |
| api_en | output | 1 | Autonomous wakeup-timer enable |

## Verification
The bench drives a stop request while the memory is busy. A design that ignored the flag would enter stop early, and one that forgot the pending request would stay in run forever. It holds masked and locally disabled interrupt lines during wait, which catches a design that wakes on any pending line. It counts oscillator-restart cycles for a non-zero delay, where an off-by-one shows as a state change one cycle early or late. It flips the select bit during pseudo-stop and enters stop with debug on, which exposes a design that re-reads the select bit or still applies the restart delay under debug.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   typedef enum logic [2:0] {
      LPM_RUN   = 3'd0,
      LPM_WAIT  = 3'd1,
      LPM_PSTOP = 3'd2,
      LPM_STOP  = 3'd3,
      LPM_OSCW  = 3'd4
   } lpm_state_t;

   typedef struct packed {
      logic cpu;
      logic per;
      logic osc;
      logic vreg;
      logic rti;
      logic cop;
      logic api;
   } lpm_en_t;

   localparam lpm_en_t LPM_ALL_ON = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, vreg: 1'b1,
                                      rti: 1'b1, cop: 1'b1, api: 1'b1};

endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
   parameter int NUM_IRQ   = 8,
   parameter int NUM_SWAKE = 3
) (
   input  logic [NUM_IRQ-1:0]   irq_pend,
   input  logic [NUM_IRQ-1:0]   irq_en,
   input  logic                 gmask,
   input  logic                 xirq,
   input  logic                 irq_ext,
   input  logic [NUM_SWAKE-1:0] stop_wake,
   output logic                 wake_dyn,
   output logic                 wake_static
);

   logic [NUM_IRQ-1:0] live;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      assign live[i] = irq_pend[i] & irq_en[i];
   end

   logic maskable_hit;
   assign maskable_hit = (|live) & ~gmask;

   // Sources that end wait; static modes additionally accept the wake pins.
   assign wake_dyn    = xirq | irq_ext | maskable_hit;
   assign wake_static = wake_dyn | (|stop_wake);

endmodule

// File: rtl/lpm_osc_timer.sv
module lpm_osc_timer #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   input  logic          active,
   output logic          done
);

   logic [DW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (active && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign done = (cnt == '0);

   // R8: restart count steps down by exactly one per active cycle
   p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1))
      else $error("restart counter did not decrement");

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
   import lpm_pkg::*;
#(
   parameter bit API_IN_STOP = 1'b1
) (
   input  lpm_state_t state,
   input  logic       dbg_en,
   input  logic       dbg_keep,
   output lpm_en_t    en
);

   logic api_stop;
   logic keep;

   if (API_IN_STOP) begin : g_api_on
      assign api_stop = 1'b1;
   end else begin : g_api_dbg
      assign api_stop = dbg_en;
   end

   assign keep = dbg_en & dbg_keep;

   always_comb begin
      en = LPM_ALL_ON;
      case (state)
         LPM_RUN: en = LPM_ALL_ON;
         LPM_WAIT: en.cpu = 1'b0;
         LPM_PSTOP: begin
            en.cpu  = keep;
            en.per  = keep;
            en.vreg = dbg_en;
         end
         LPM_STOP: begin
            en.cpu  = keep;
            en.per  = keep;
            en.osc  = dbg_en;
            en.vreg = dbg_en;
            en.rti  = dbg_en;
            en.cop  = dbg_en;
            en.api  = api_stop;
         end
         LPM_OSCW: begin
            en.cpu = 1'b0;
            en.per = 1'b0;
            en.rti = 1'b0;
            en.cop = 1'b0;
            en.api = api_stop;
         end
         default: en = LPM_ALL_ON;
      endcase
   end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
   import lpm_pkg::*;
#(
   parameter int NUM_IRQ     = 8,
   parameter int NUM_SWAKE   = 3,
   parameter int DW          = 8,
   parameter bit API_IN_STOP = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wait_req,
   input  logic                 stop_req,
   input  logic                 nvm_busy,
   input  logic                 pstop_sel,
   input  logic                 xirq,
   input  logic                 irq_ext,
   input  logic [NUM_IRQ-1:0]   irq_pend,
   input  logic [NUM_IRQ-1:0]   irq_en,
   input  logic                 gmask,
   input  logic [NUM_SWAKE-1:0] stop_wake,
   input  logic                 dbg_en,
   input  logic                 dbg_keep,
   input  logic [DW-1:0]        osc_delay,
   output logic [2:0]           lp_state,
   output logic                 cpu_clk_en,
   output logic                 per_clk_en,
   output logic                 osc_en,
   output logic                 vreg_full,
   output logic                 rti_en,
   output logic                 cop_en,
   output logic                 api_en
);

   if (NUM_IRQ < 1) begin : g_bad_irq
      $error("NUM_IRQ must be at least 1");
   end
   if (NUM_SWAKE < 1) begin : g_bad_swake
      $error("NUM_SWAKE must be at least 1");
   end
   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("DW must lie in 1..32");
   end

   lpm_state_t state_q, state_d;
   logic       pend_q, pend_d;
   logic       wake_dyn, wake_static;
   logic       t_load, t_done;
   logic       ack;
   lpm_en_t    en;

   lpm_wake_detect #(.NUM_IRQ(NUM_IRQ), .NUM_SWAKE(NUM_SWAKE)) u_wake (
      .irq_pend    (irq_pend),
      .irq_en      (irq_en),
      .gmask       (gmask),
      .xirq        (xirq),
      .irq_ext     (irq_ext),
      .stop_wake   (stop_wake),
      .wake_dyn    (wake_dyn),
      .wake_static (wake_static)
   );

   // Stop acceptance: wait wins, memory activity defers.
   assign ack    = (state_q == LPM_RUN) && !wait_req && (stop_req || pend_q) && !nvm_busy;
   assign t_load = (state_q == LPM_STOP) && wake_static && !dbg_en;

   always_comb begin
      state_d = state_q;
      pend_d  = pend_q;
      case (state_q)
         LPM_RUN: begin
            pend_d = !ack && (pend_q || stop_req);
            if (wait_req)  state_d = LPM_WAIT;
            else if (ack)  state_d = pstop_sel ? LPM_PSTOP : LPM_STOP;
         end
         LPM_WAIT:  if (wake_dyn)    state_d = LPM_RUN;
         LPM_PSTOP: if (wake_static) state_d = LPM_RUN;
         LPM_STOP:  if (wake_static) state_d = dbg_en ? LPM_RUN : LPM_OSCW;
         LPM_OSCW:  if (t_done)      state_d = LPM_RUN;
         default:   state_d = LPM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LPM_RUN;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
      end
   end

   lpm_osc_timer #(.DW(DW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (osc_delay),
      .active   (state_q == LPM_OSCW),
      .done     (t_done)
   );

   lpm_clk_ctrl #(.API_IN_STOP(API_IN_STOP)) u_clk (
      .state    (state_q),
      .dbg_en   (dbg_en),
      .dbg_keep (dbg_keep),
      .en       (en)
   );

   assign lp_state   = state_q;
   assign cpu_clk_en = en.cpu;
   assign per_clk_en = en.per;
   assign osc_en     = en.osc;
   assign vreg_full  = en.vreg;
   assign rti_en     = en.rti;
   assign cop_en     = en.cop;
   assign api_en     = en.api;

   p_reset_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (state_q == LPM_RUN && cpu_clk_en && osc_en))
      else $error("not in run after reset");

   p_wait_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_WAIT) |-> (!cpu_clk_en && per_clk_en && osc_en))
      else $error("wait clock gating wrong");

   p_wait_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_WAIT && wake_dyn) |=> (state_q == LPM_RUN))
      else $error("wait not left on wake");

   p_nvm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_RUN && nvm_busy) |=> (state_q == LPM_RUN || state_q == LPM_WAIT))
      else $error("stop entered while memory busy");

   p_pstop_osc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_PSTOP) |-> (osc_en && rti_en && cop_en))
      else $error("pseudo-stop lost oscillator or timers");

   p_stop_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_STOP && !dbg_en) |-> (!osc_en && !cpu_clk_en && !per_clk_en))
      else $error("full stop not gated");

   p_pstop_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_PSTOP && wake_static) |=> (state_q == LPM_RUN))
      else $error("pseudo-stop wake not direct");

   p_dbg_vreg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == LPM_STOP || state_q == LPM_PSTOP) && dbg_en) |-> (vreg_full && osc_en))
      else $error("debug did not hold regulator");

   p_dbg_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LPM_STOP && dbg_en && wake_static) |=> (state_q == LPM_RUN))
      else $error("debug wake applied delay");

   p_keep_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == LPM_STOP || state_q == LPM_PSTOP) && dbg_en && dbg_keep) |-> (per_clk_en && cpu_clk_en))
      else $error("debug clock keep ignored");

endmodule

// File: tb/sim_lpm_sequencer.sv
module sim_lpm_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int NI = 8;
   localparam int NS = 3;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wait_req = 0, stop_req = 0, nvm_busy = 0, pstop_sel = 0;
   logic xirq = 0, irq_ext = 0, gmask = 0, dbg_en = 0, dbg_keep = 0;
   logic [NI-1:0] irq_pend = '0, irq_en = '0;
   logic [NS-1:0] stop_wake = '0;
   logic [DW-1:0] osc_delay = '0;
   logic [2:0] lp_state;
   logic cpu_clk_en, per_clk_en, osc_en, vreg_full, rti_en, cop_en, api_en;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // bench model
   int  ms = 0;
   bit  mpend = 0;
   int  mcnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lpm_sequencer #(.NUM_IRQ(NI), .NUM_SWAKE(NS), .DW(DW)) u0 (
      .clk, .rst_n, .wait_req, .stop_req, .nvm_busy, .pstop_sel, .xirq, .irq_ext,
      .irq_pend, .irq_en, .gmask, .stop_wake, .dbg_en, .dbg_keep, .osc_delay,
      .lp_state, .cpu_clk_en, .per_clk_en, .osc_en, .vreg_full, .rti_en, .cop_en, .api_en
   );

   function automatic bit w_dyn();
      return xirq || irq_ext || ((|(irq_pend & irq_en)) && !gmask);
   endfunction

   function automatic bit w_stat();
      return w_dyn() || (|stop_wake);
   endfunction

   // order: cpu per osc vreg rti cop api
   function automatic logic [6:0] exp_out(int s, bit d, bit k);
      bit kk = d & k;
      case (s)
         0: return 7'b1111111;
         1: return 7'b0111111;
         2: return {kk, kk, 1'b1, d, 1'b1, 1'b1, 1'b1};
         3: return {kk, kk, d, d, d, d, 1'b1};
         default: return 7'b0011001;
      endcase
   endfunction

   function automatic string tag_of(int s, bit d);
      case (s)
         0: return "R1";
         1: return "R2";
         2: return d ? "R9" : "R5";
         3: return d ? "R10" : "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_update();
      bit ack;
      if (!rst_n) begin
         ms = 0; mpend = 0; mcnt = 0;
         return;
      end
      case (ms)
         0: begin
            ack = !wait_req && (stop_req || mpend) && !nvm_busy;
            mpend = !ack && (mpend || stop_req);
            if (wait_req) ms = 1;
            else if (ack) ms = pstop_sel ? 2 : 3;
         end
         1: if (w_dyn()) ms = 0;
         2: if (w_stat()) ms = 0;
         3: if (w_stat()) begin
               if (dbg_en) ms = 0;
               else begin ms = 4; mcnt = int'(osc_delay); end
            end
         default: if (mcnt == 0) ms = 0; else mcnt--;
      endcase
   endtask

   task automatic cycle();
      logic [6:0] act, exp;
      @(posedge clk);
      model_update();
      @(negedge clk);
      exp = exp_out(ms, dbg_en, dbg_keep);
      act = {cpu_clk_en, per_clk_en, osc_en, vreg_full, rti_en, cop_en, api_en};
      chk(int'(lp_state) == ms, "R11 state", int'(lp_state), ms);
      chk(act == exp, tag_of(ms, dbg_en), int'(act), int'(exp));
   endtask

   task automatic idle();
      wait_req = 0; stop_req = 0; nvm_busy = 0; pstop_sel = 0; xirq = 0; irq_ext = 0;
      gmask = 0; dbg_en = 0; dbg_keep = 0; irq_pend = '0; irq_en = '0; stop_wake = '0;
      osc_delay = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      idle();
      // R1 reset
      rst_n = 0;
      repeat (3) cycle();
      chk(lp_state == 3'd0 && cpu_clk_en && osc_en && api_en, "R1", int'(lp_state), 0);
      rst_n = 1;
      cycle();
      chk(lp_state == 3'd0, "R1", int'(lp_state), 0);

      // R4 stop held off by memory activity
      nvm_busy = 1; stop_req = 1; cycle();
      stop_req = 0; repeat (3) cycle();
      chk(lp_state == 3'd0, "R4", int'(lp_state), 0);
      nvm_busy = 0; pstop_sel = 0; cycle();
      chk(lp_state == 3'd3, "R4", int'(lp_state), 3);
      chk(!osc_en && !per_clk_en && api_en, "R6", int'(osc_en), 0);
      // R7 requests ignored in stop
      wait_req = 1; stop_req = 1; cycle();
      chk(lp_state == 3'd3, "R7", int'(lp_state), 3);
      wait_req = 0; stop_req = 0;
      // R8 restart delay of 3
      osc_delay = 8'd3; stop_wake[1] = 1; cycle();
      stop_wake = '0; osc_delay = 8'd0;
      chk(lp_state == 3'd4, "R8", int'(lp_state), 4);
      repeat (3) cycle();
      chk(lp_state == 3'd4, "R8", int'(lp_state), 4);
      cycle();
      chk(lp_state == 3'd0, "R8", int'(lp_state), 0);

      // R2 / R3 wait with masked lines
      wait_req = 1; cycle(); wait_req = 0;
      chk(lp_state == 3'd1 && !cpu_clk_en && per_clk_en, "R2", int'(lp_state), 1);
      gmask = 1; irq_pend = 8'h10; irq_en = 8'h10; cycle();
      chk(lp_state == 3'd1, "R3", int'(lp_state), 1);
      gmask = 0; irq_en = 8'h00; cycle();
      chk(lp_state == 3'd1, "R3", int'(lp_state), 1);
      irq_en = 8'h10; cycle();
      chk(lp_state == 3'd0, "R3", int'(lp_state), 0);
      idle();

      // R5 pseudo-stop, select sampled only at acceptance
      pstop_sel = 1; stop_req = 1; cycle(); stop_req = 0;
      chk(lp_state == 3'd2 && osc_en, "R5", int'(lp_state), 2);
      pstop_sel = 0; cycle();
      chk(lp_state == 3'd2, "R5", int'(lp_state), 2);
      xirq = 1; cycle(); xirq = 0;
      chk(lp_state == 3'd0, "R8", int'(lp_state), 0);

      // R9 / R10 debug in full stop
      dbg_en = 1; dbg_keep = 1; stop_req = 1; cycle(); stop_req = 0;
      chk(lp_state == 3'd3 && vreg_full && osc_en, "R9", int'(vreg_full), 1);
      chk(per_clk_en && cpu_clk_en, "R10", int'(per_clk_en), 1);
      osc_delay = 8'd5; irq_ext = 1; cycle(); irq_ext = 0;
      chk(lp_state == 3'd0, "R9", int'(lp_state), 0);
      idle();

      // random phase
      for (int i = 0; i < 4000; i++) begin
         wait_req  = ($urandom % 8) == 0;
         stop_req  = ($urandom % 6) == 0;
         nvm_busy  = ($urandom % 3) == 0;
         pstop_sel = $urandom % 2;
         xirq      = ($urandom % 40) == 0;
         irq_ext   = ($urandom % 30) == 0;
         gmask     = $urandom % 2;
         irq_pend  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
         irq_en    = 8'($urandom);
         stop_wake = (($urandom % 12) == 0) ? 3'($urandom) : 3'b000;
         dbg_en    = ($urandom % 4) == 0;
         dbg_keep  = $urandom % 2;
         osc_delay = 8'($urandom % 8);
         rst_n     = ($urandom % 700) != 0;
         cycle();
      end
      rst_n = 1;
      idle();
      cycle();

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule